// File: doc/BRIEF.md
# Filtered External Interrupt Input

This block prepares one asynchronous external pin for two uses: as an interrupt request and as an event input for a timer. The pin first passes through a two-stage synchronizer. A digital noise filter then samples it once per sampling period. Software picks that period from three settings: every cycle, every 32 cycles, or every 128 cycles. The filtered level changes only when two consecutive samples agree on a new value. A pulse must therefore last at least twice the sampling period to be sure of acceptance, and a pulse shorter than one period is always rejected.

On the filtered level the block detects rising edges, falling edges or both, depending on the edge mode. Each accepted edge gives a one-cycle event pulse, which a timer can count. The same edge sets a sticky interrupt flag. The flag stays set until software sends a clear strobe. If a new edge arrives in the same cycle as the clear, the edge wins. The enable input gates both the event pulse and the flag setting. The filtered level output follows the pin whether or not the block is enabled. Detection on a steady high or low level is not offered.

Top module: `pin_event_conditioner`

## Requirements
- R1: After a synchronous reset, `level_out`, `event_pulse` and `irq_flag` are 0. The pin reaches the filter through two flip-flops. With `flt_sel`=00, a pin that goes high just before clock edge e0 shows on `level_out` after edge e3 and not after edge e2.
- R2: With `flt_sel`=00 (the filter samples every cycle), a 1-cycle pulse on the pin is rejected and a pulse of 2 or more cycles is accepted.
- R3: With `flt_sel`=01 (the filter samples every 32 cycles), a pulse of 31 cycles or less is rejected and a pulse of 64 cycles or more is accepted.
- R4: With `flt_sel`=10 or 11 (the filter samples every 128 cycles), a pulse of 127 cycles or less is rejected and a pulse of 256 cycles or more is accepted.
- R5: `level_out` changes only on a filter sample, and only when that sample equals the previous sample.
- R6: With `edge_mode`=00, only rising edges of the filtered level produce an event.
- R7: With `edge_mode`=01, only falling edges of the filtered level produce an event.
- R8: With `edge_mode`=10 or 11, both rising and falling edges produce an event.
- R9: Each accepted edge gives an `event_pulse` that is high for exactly one clock cycle.
- R10: An event sets `irq_flag` in the next cycle. The flag stays at 1 until `flag_clr` is high in a cycle with no event, and it is 0 from the following cycle.
- R11: When an event and `flag_clr` occur in the same cycle, `irq_flag` is 1 afterwards.
- R12: While `enable` is 0, there is no `event_pulse` and `irq_flag` is not set, but `level_out` still follows the filtered pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | 1 | Asynchronous external pin |
| flt_sel | input | 2 | Filter sampling period: 00 = 1 cycle, 01 = 32 cycles, 1x = 128 cycles |
| edge_mode | input | 2 | Edge to detect: 00 = rising, 01 = falling, 1x = both |
| enable | input | 1 | Enables the event pulse and the setting of the flag |
| flag_clr | input | 1 | One-cycle strobe that clears the interrupt flag |
| level_out | output | 1 | Filtered pin level |
| event_pulse | output | 1 | One-cycle pulse for each accepted edge, intended for a timer |
| irq_flag | output | 1 | Sticky interrupt request flag |

## Verification
The assertions assume that `flt_sel` and `edge_mode` stay constant while a pulse is being filtered. If either changes mid-pulse, the acceptance bounds for the pulse width and the edge-direction checks no longer have a defined meaning. They also assume that `flag_clr` is used as a strobe and not held high through an event. The stimulus changes the configuration only after the pin has been low and idle for several hundred cycles, so the filter has settled. It keeps pulse widths at or below one sampling period, or at or above two periods, so that every expected result is exact. It drives `flag_clr` for single cycles only, and raises it together with an event only in the one test that deliberately checks that a set wins over a clear.

// File: rtl/pec_pkg.sv
package pec_pkg;

    typedef enum logic [1:0] {
        FLT_FAST     = 2'b00,
        FLT_MID      = 2'b01,
        FLT_SLOW     = 2'b10,
        FLT_SLOW_ALT = 2'b11
    } flt_sel_e;

    typedef enum logic [1:0] {
        EDGE_RISE     = 2'b00,
        EDGE_FALL     = 2'b01,
        EDGE_BOTH     = 2'b10,
        EDGE_BOTH_ALT = 2'b11
    } edge_mode_e;

    // Filtered level together with its edge qualifiers
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } lvl_evt_t;

    function automatic logic edge_hit(edge_mode_e mode, logic rise, logic fall);
        logic hit;
        case (mode)
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            default:   hit = rise | fall;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/pec_sync.sv
module pec_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];

    initial begin
        if (STAGES < 2) $error("pec_sync needs at least two stages");
    end
endmodule

// File: rtl/pec_tick_gen.sv
module pec_tick_gen
    import pec_pkg::*;
#(
    parameter int MID_DIV  = 32,
    parameter int SLOW_DIV = 128
) (
    input  logic     clk,
    input  logic     rst,
    input  flt_sel_e sel,
    output logic     tick
);
    localparam int CNT_W = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
    localparam logic [CNT_W-1:0] MID_LIM  = CNT_W'(MID_DIV - 1);
    localparam logic [CNT_W-1:0] SLOW_LIM = CNT_W'(SLOW_DIV - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    always_comb begin
        case (sel)
            FLT_FAST: lim = '0;
            FLT_MID:  lim = MID_LIM;
            default:  lim = SLOW_LIM;
        endcase
    end

    assign tick = (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // R2: the fastest setting samples every cycle
    a_r2_fast_tick: assert property (@(posedge clk) disable iff (rst)
        (sel == FLT_FAST && $past(sel) == FLT_FAST && !$past(rst)) |-> (tick && $past(tick)));

    initial begin
        if (MID_DIV < 2 || SLOW_DIV < MID_DIV)
            $error("pec_tick_gen divider parameters out of order");
    end
endmodule

// File: rtl/pec_glitch_filter.sv
module pec_glitch_filter
    import pec_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     din,
    output lvl_evt_t lvl
);
    logic smp;
    logic level;
    logic level_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp   <= 1'b0;
            level <= 1'b0;
        end else if (tick) begin
            smp <= din;
            if (din == smp && din != level) level <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) level_d <= 1'b0;
        else     level_d <= level;
    end

    assign lvl.level = level;
    assign lvl.rise  = level & ~level_d;
    assign lvl.fall  = ~level & level_d;

    // R5: level only moves on a sample that agrees with the one before
    a_r5_change_on_tick: assert property (@(posedge clk) disable iff (rst)
        (level != $past(level)) |-> $past(tick));
    a_r5_two_agree: assert property (@(posedge clk) disable iff (rst)
        (level != $past(level)) |-> ($past(din) == $past(smp)));
    // R9: filtered edges are never adjacent
    a_r9_edge_spacing: assert property (@(posedge clk) disable iff (rst)
        (lvl.rise || lvl.fall) |=> !(lvl.rise || lvl.fall));
endmodule

// File: rtl/pec_edge_flag.sv
module pec_edge_flag
    import pec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  edge_mode_e mode,
    input  logic       clr,
    input  lvl_evt_t   lvl,
    output logic       event_o,
    output logic       flag
);
    assign event_o = enable & edge_hit(mode, lvl.rise, lvl.fall);

    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (event_o) flag <= 1'b1;
        else if (clr)     flag <= 1'b0;
    end

    // R9: one cycle per edge
    a_r9_single_cycle: assert property (@(posedge clk) disable iff (rst)
        event_o |=> !event_o);
    // R12: gated when disabled
    a_r12_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !event_o);
    // R6: rising mode only fires with the level high
    a_r6_rise_only: assert property (@(posedge clk) disable iff (rst)
        (mode == EDGE_RISE && event_o) |-> lvl.level);
    // R7: falling mode only fires with the level low
    a_r7_fall_only: assert property (@(posedge clk) disable iff (rst)
        (mode == EDGE_FALL && event_o) |-> !lvl.level);
    // R10: sticky until cleared
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !event_o) |=> !flag);
    // R11: set beats clear
    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
        event_o |=> flag);
endmodule

// File: rtl/pin_event_conditioner.sv
module pin_event_conditioner
    import pec_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MID_DIV     = 32,
    parameter int SLOW_DIV    = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_raw,
    input  logic [1:0] flt_sel,
    input  logic [1:0] edge_mode,
    input  logic       enable,
    input  logic       flag_clr,
    output logic       level_out,
    output logic       event_pulse,
    output logic       irq_flag
);
    logic     pin_sync;
    logic     tick;
    lvl_evt_t lvl;

    pec_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_raw),
        .dout (pin_sync)
    );

    pec_tick_gen #(.MID_DIV(MID_DIV), .SLOW_DIV(SLOW_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .sel  (flt_sel_e'(flt_sel)),
        .tick (tick)
    );

    pec_glitch_filter u_filt (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .din  (pin_sync),
        .lvl  (lvl)
    );

    pec_edge_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .mode    (edge_mode_e'(edge_mode)),
        .clr     (flag_clr),
        .lvl     (lvl),
        .event_o (event_pulse),
        .flag    (irq_flag)
    );

    assign level_out = lvl.level;

    // R1: quiet outputs in the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!level_out && !event_pulse && !irq_flag));
endmodule

// File: tb/sim_pin_event_conditioner.sv
module sim_pin_event_conditioner;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin_raw = 1'b0;
    logic [1:0] flt_sel = 2'b00;
    logic [1:0] edge_mode = 2'b00;
    logic       enable = 1'b1;
    logic       flag_clr = 1'b0;
    logic       level_out, event_pulse, irq_flag;

    int checks = 0;
    int failures = 0;
    int ev_cnt = 0;
    bit seen_hi = 0;
    bit mon_on = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    pin_event_conditioner u0 (
        .clk(clk), .rst(rst), .pin_raw(pin_raw), .flt_sel(flt_sel),
        .edge_mode(edge_mode), .enable(enable), .flag_clr(flag_clr),
        .level_out(level_out), .event_pulse(event_pulse), .irq_flag(irq_flag)
    );

    // Vectors: filter select, edge mode, high pulse width, expected events
    localparam int NV = 12;
    localparam int V_SEL[NV]   = '{0, 0, 0, 0, 1,  1,  1,   2,   2,   3,   3, 0};
    localparam int V_MODE[NV]  = '{0, 0, 1, 2, 0,  2,  1,   0,   2,   1,   0, 3};
    localparam int V_WIDTH[NV] = '{1, 2, 2, 3, 31, 64, 70, 127, 256, 256, 100, 5};
    localparam int V_EXP[NV]   = '{0, 1, 1, 2, 0,  2,  1,   0,   2,   1,   0, 2};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string sel_tag(input int s);
        if (s == 0) return "R2";
        if (s == 1) return "R3";
        return "R4";
    endfunction

    function automatic string mode_tag(input int m);
        if (m == 0) return "R6";
        if (m == 1) return "R7";
        return "R8";
    endfunction

    always @(negedge clk) begin
        cycles++;
        if (mon_on && !rst) begin
            if (event_pulse) ev_cnt++;
            if (level_out) seen_hi = 1;
        end
    end

    always @(negedge clk) begin
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe_clear();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic pulse(input int w);
        pin_raw = 1'b1;
        repeat (w) @(negedge clk);
        pin_raw = 1'b0;
    endtask

    task automatic arm();
        idle(300);
        mon_on = 0;
        ev_cnt = 0;
        seen_hi = 0;
        mon_on = 1;
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(level_out == 0, "R1 level after reset", level_out, 0);
        chk(event_pulse == 0, "R1 event after reset", event_pulse, 0);
        chk(irq_flag == 0, "R1 flag after reset", irq_flag, 0);

        // R1 / R5 latency through synchronizer and filter with select 00
        flt_sel = 2'b00; edge_mode = 2'b00;
        idle(10);
        pin_raw = 1'b1;
        idle(3);
        chk(level_out == 0, "R1 level not yet after e2", level_out, 0);
        @(negedge clk);
        chk(level_out == 1, "R1 level after e3", level_out, 1);
        pin_raw = 1'b0;
        idle(10);
        strobe_clear();

        // Table walk
        for (int i = 0; i < NV; i++) begin
            flt_sel   = V_SEL[i][1:0];
            edge_mode = V_MODE[i][1:0];
            arm();
            strobe_clear();
            chk(irq_flag == 0, "R10 clear before vector", irq_flag, 0);
            pulse(V_WIDTH[i]);
            idle(600);
            chk(ev_cnt == V_EXP[i], mode_tag(V_MODE[i]), ev_cnt, V_EXP[i]);
            chk(int'(seen_hi) == int'(V_EXP[i] > 0), sel_tag(V_SEL[i]),
                int'(seen_hi), int'(V_EXP[i] > 0));
            chk(irq_flag == (V_EXP[i] > 0), "R10 flag after vector",
                irq_flag, int'(V_EXP[i] > 0));
            chk(level_out == 0, "R5 level back low", level_out, 0);
        end

        // R12: disabled, level still follows
        flt_sel = 2'b00; edge_mode = 2'b10; enable = 1'b0;
        arm();
        strobe_clear();
        pulse(10);
        idle(50);
        chk(ev_cnt == 0, "R12 no events while disabled", ev_cnt, 0);
        chk(irq_flag == 0, "R12 no flag while disabled", irq_flag, 0);
        chk(seen_hi == 1, "R12 level follows while disabled", int'(seen_hi), 1);
        enable = 1'b1;

        // R9 / R10: sticky flag, then clear
        edge_mode = 2'b00;
        arm();
        pulse(10);
        idle(50);
        chk(ev_cnt == 1, "R9 one event pulse per edge", ev_cnt, 1);
        idle(200);
        chk(irq_flag == 1, "R10 flag stays set", irq_flag, 1);
        strobe_clear();
        chk(irq_flag == 0, "R10 flag cleared by strobe", irq_flag, 0);

        // R11: clear in the same cycle as an event
        arm();
        pin_raw = 1'b1;
        for (int k = 0; k < 20 && !event_pulse; k++) @(negedge clk);
        chk(event_pulse == 1, "R11 event seen", event_pulse, 1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk(irq_flag == 1, "R11 set wins over clear", irq_flag, 1);
        pin_raw = 1'b0;
        idle(20);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule